// File: doc/BRIEF.md
# Most-Frequent Byte Finder

This block collects a stream of 8-bit result values and, on request, reports the value that occurred most often together with the number of times it occurred. A typical use is repeated measurement: each trial produces one byte, and the byte that keeps coming back is taken as the answer. A decision may rest on any number of samples, from a single one up to more than a hundred thousand.

Each value has its own occurrence counter. A clear request empties every counter in one cycle, using a per-bin "live" bit rather than rewriting the counter storage. A finish request starts a sequential scan that visits every bin once, from the lowest value to the highest, and keeps the best candidate seen so far. The scan takes one cycle per bin. While it runs, the block reports busy and ignores all requests. When the scan ends, the winner is presented with a one-cycle result strobe. Finishing does not empty the counters, so later samples add to the same totals.

Top module: `mode_finder`

## Requirements
- R1: After reset, busy_o and res_valid_o are low and every counter reads as zero.
- R2: Each sample taken while idle, with no clear or finish in the same cycle, raises the count of its value by exactly one. The reported count equals the number of such samples of the winning value.
- R3: The reported value is the value whose count is the highest.
- R4: When several values share the highest count, the numerically lowest of them is reported.
- R5: Counters are 17 bits wide. They hold at least 65536 without wrapping and saturate at 131071.
- R6: A finish request accepted while idle raises busy_o in the next cycle and keeps it high for exactly 256 cycles. While busy_o is high, samples, clear and finish requests have no effect.
- R7: res_valid_o is high for exactly one cycle: the first cycle after busy_o falls. In that cycle res_value_o and res_count_o carry the winner.
- R8: A clear accepted while idle empties all counters in one cycle. When requests coincide, clear takes precedence over finish, and finish takes precedence over a sample. The request that loses has no effect.
- R9: A finish with all counters empty reports value 0 with count 0.
- R10: A finish does not clear the counters, so counts keep accumulating across decisions until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Empty all counters |
| finish_i | input | 1 | Start the scan for the most frequent value |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 8 | Sample value |
| busy_o | output | 1 | Scan in progress; requests are ignored |
| res_valid_o | output | 1 | One-cycle strobe: a result is present |
| res_value_o | output | 8 | Most frequent value |
| res_count_o | output | 17 | Occurrence count of that value |

## Verification
A wrong counter or a stale live bit stays hidden until the next finish. It then shows up as a wrong value or a wrong count in the result strobe, about 257 cycles after the finish request. Errors in the scan sequencing show up sooner. They appear as a busy window of the wrong length, or as a strobe that is missing, repeated or misplaced, and a reference model compared every clock catches these in the cycle they occur. The ignore rules, tie order, saturation and request priorities each get a scenario. In every one, a later result would expose any sample that was wrongly counted.

// File: rtl/mode_finder.sv
module mode_finder #(
  parameter int VAL_W = 8,
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             finish_i,
  input  logic             smp_valid_i,
  input  logic [VAL_W-1:0] smp_data_i,
  output logic             busy_o,
  output logic             res_valid_o,
  output logic [VAL_W-1:0] res_value_o,
  output logic [CNT_W-1:0] res_count_o
);
  localparam int NBINS = 1 << VAL_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [VAL_W-1:0] LAST = VAL_W'(NBINS - 1);

  logic             scanning, rv;
  logic [VAL_W-1:0] idx, best_val;
  logic [CNT_W-1:0] best_cnt, cur, old;
  logic [NBINS-1:0] live;
  logic [CNT_W-1:0] cnt [NBINS];

  wire take_clr = clr_i && !scanning;
  wire start    = finish_i && !scanning && !clr_i;
  wire take     = smp_valid_i && !scanning && !clr_i && !finish_i;

  assign cur = live[idx] ? cnt[idx] : '0;
  assign old = cnt[smp_data_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scanning <= 1'b0;
      rv       <= 1'b0;
      idx      <= '0;
      best_val <= '0;
      best_cnt <= '0;
      live     <= '0;
    end else begin
      rv <= 1'b0;
      if (scanning) begin
        if (cur > best_cnt) begin
          best_val <= idx;
          best_cnt <= cur;
        end
        idx <= idx + 1'b1;
        if (idx == LAST) begin
          scanning <= 1'b0;
          rv       <= 1'b1;
        end
      end else if (take_clr) begin
        live <= '0;
      end else if (start) begin
        scanning <= 1'b1;
        idx      <= '0;
        best_val <= '0;
        best_cnt <= '0;
      end else if (take) begin
        live[smp_data_i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take)
      cnt[smp_data_i] <= !live[smp_data_i] ? CNT_W'(1) :
                         (old == CMAX) ? CMAX : old + 1'b1;
  end

  assign busy_o      = scanning;
  assign res_valid_o = rv;
  assign res_value_o = best_val;
  assign res_count_o = best_cnt;

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);
  p_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> res_valid_o);
  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && finish_i && !clr_i) |=> busy_o);
  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(live));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && clr_i) |=> (live == '0));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && live[smp_data_i] && old == CMAX) |=> (cnt[$past(smp_data_i)] == CMAX));
  p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_count_o == '0) |-> (res_value_o == '0));
endmodule

// File: tb/sim_mode_finder.sv
`timescale 1ns/1ps
module sim_mode_finder;
  localparam int SATMAX = 131071;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_i = 1'b0, finish_i = 1'b0, smp_valid_i = 1'b0;
  logic [7:0]  smp_data_i = '0;
  logic        busy_o, res_valid_o;
  logic [7:0]  res_value_o;
  logic [16:0] res_count_o;

  int compared = 0, mismatched = 0;
  int ref_cnt [256];
  bit m_busy = 0, m_rv = 0;
  int m_val = 0, m_cnt = 0, left = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mode_finder u0 (.clk(clk), .rst_n(rst_n), .clr_i(clr_i), .finish_i(finish_i),
    .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i), .busy_o(busy_o),
    .res_valid_o(res_valid_o), .res_value_o(res_value_o), .res_count_o(res_count_o));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_rv = 0; m_val = 0; m_cnt = 0;
      foreach (ref_cnt[i]) ref_cnt[i] = 0;
    end else begin
      m_rv = 0;
      if (m_busy) begin
        left--;
        if (left == 0) begin
          m_busy = 0; m_rv = 1; m_val = 0; m_cnt = 0;
          for (int i = 0; i < 256; i++)
            if (ref_cnt[i] > m_cnt) begin m_cnt = ref_cnt[i]; m_val = i; end
        end
      end else if (clr_i) begin
        foreach (ref_cnt[i]) ref_cnt[i] = 0;
      end else if (finish_i) begin
        m_busy = 1; left = 256;
      end else if (smp_valid_i) begin
        if (ref_cnt[smp_data_i] < SATMAX) ref_cnt[smp_data_i]++;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    compared++;
    if (busy_o !== m_busy) begin
      mismatched++; $display("FAIL R6 busy: got %0b expected %0b", busy_o, m_busy);
    end
    if (res_valid_o !== m_rv) begin
      mismatched++; $display("FAIL R7 res_valid: got %0b expected %0b", res_valid_o, m_rv);
    end
    if (m_rv && (res_value_o !== m_val[7:0] || res_count_o !== m_cnt[16:0])) begin
      mismatched++;
      $display("FAIL R3 result: got %0h/%0d expected %0h/%0d", res_value_o, res_count_o, m_val, m_cnt);
    end
  end

  task automatic drive(bit c, bit f, bit v, logic [7:0] d);
    clr_i = c; finish_i = f; smp_valid_i = v; smp_data_i = d;
    @(negedge clk);
    clr_i = 0; finish_i = 0; smp_valid_i = 0;
  endtask

  task automatic feed(logic [7:0] d, int n);
    for (int i = 0; i < n; i++) drive(0, 0, 1, d);
  endtask

  task automatic expect_res(int val, int cnt, string tag);
    int k = 0;
    while (!res_valid_o && k < 400) begin @(negedge clk); k++; end
    compared++;
    if (!res_valid_o || res_value_o !== val[7:0] || res_count_o !== cnt[16:0]) begin
      mismatched++;
      $display("FAIL %s: got %0b %0h/%0d expected 1 %0h/%0d", tag, res_valid_o,
               res_value_o, res_count_o, val, cnt);
    end
    @(negedge clk);
  endtask

  initial begin
    #(195000 * 5);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (busy_o !== 0 || res_valid_o !== 0) begin
      mismatched++; $display("FAIL R1 reset: got %0b%0b expected 00", busy_o, res_valid_o);
    end
    rst_n = 1;
    @(negedge clk);
    drive(0, 1, 0, 0);
    expect_res(0, 0, "R9 empty");
    feed(8'h10, 3); feed(8'hFB, 5); feed(8'h03, 2);
    drive(0, 1, 0, 0);
    expect_res(8'hFB, 5, "R2 R3 counting");
    feed(8'h10, 3);
    drive(0, 1, 0, 0);
    expect_res(8'h10, 6, "R10 accumulate");
    feed(8'hFB, 1);
    drive(0, 1, 0, 0);
    expect_res(8'h10, 6, "R4 tie lowest");
    drive(0, 1, 0, 0);
    feed(8'h99, 20); drive(1, 0, 0, 0); drive(0, 1, 1, 8'h99);
    expect_res(8'h10, 6, "R6 busy ignores");
    drive(0, 1, 0, 0);
    expect_res(8'h10, 6, "R6 ignored samples not counted");
    drive(1, 1, 1, 8'h44);
    drive(0, 1, 0, 0);
    expect_res(0, 0, "R8 clear priority");
    drive(0, 1, 1, 8'h77);
    expect_res(0, 0, "R8 finish beats sample");
    feed(8'hC4, 1);
    drive(0, 1, 0, 0);
    expect_res(8'hC4, 1, "R2 single sample");
    drive(1, 0, 0, 0);
    feed(8'h5A, 65536); feed(8'h5B, 2);
    drive(0, 1, 0, 0);
    expect_res(8'h5A, 65536, "R5 no wrap");
    feed(8'h5A, 65540);
    drive(0, 1, 0, 0);
    expect_res(8'h5A, SATMAX, "R5 saturate");
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule